// File: doc/BRIEF.md
# Burst and Write-Near Bus Sequencer

This block runs one transaction at a time on a multiplexed address/data bus for a small processor's bus interface. It accepts a request only while it is idle and latches the request's address. It then asserts either the read output or the write output until the transaction completes. A single shared burst/near output carries two meanings. During a read it asks memory for a four-word block refill. During a write it tells memory that this write follows the previous write back-to-back and falls in the same page.

Reads come in two sizes. A cache-miss refill that qualifies takes a whole block, and any other read takes a single word. Each returned word is written into the read buffer on a cycle where the memory side raises the capture enable. Acknowledge completes the read once every word is in the buffer. Writes may span several acknowledge-paced beats, for a wide datum going into narrow memory, and the last acknowledged beat ends the write. A one-cycle completion strobe marks the last cycle of every transaction.

Top module: `burst_near_seq`

## Requirements
- R1: After reset, and whenever no transaction is active, rd_o, wr_o, burst_near_o, done_o and rbuf_we_o are all low.
- R2: A request accepted on a clock edge raises wr_o when req_write_i=1, or rd_o when req_write_i=0, from that edge until completion. The other output stays low. addr_o holds the request address throughout.
- R3: On a read, burst_near_o is high if and only if req_refill_i=1 and either req_icache_i=1 or cfg_dblk_refill_i=1. A block read takes BLK_WORDS words, and any other read takes one word.
- R4: During a read, a cycle with rdcap_i=1 and words still outstanding raises rbuf_we_o, with rbuf_data_o=rdata_i and rbuf_idx_o equal to the word number, counting from 0. A capture after the last word of a read, or a capture during a write, has no effect.
- R5: A read completes, with done_o high, in the first cycle where ack_i=1 and all of its words have been captured, counting a capture made in that same cycle. An acknowledge given earlier has no effect.
- R6: A write runs req_wlen_i+1 beats. Each ack_i pulse ends one beat, and done_o rises with the acknowledge of the final beat.
- R7: On a write, burst_near_o is high if and only if the request was accepted in the first idle cycle after a completed write, and address bits [ADDR_W-1:PAGE_W] equal those of that previous write.
- R8: Any idle cycle without a write accept breaks the back-to-back chain, and an accepted read breaks it too. The next write then has burst_near_o low even when its page matches.
- R9: Requests are accepted only while idle. A request presented during an active transaction is ignored, and the cycle after done_o is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Transaction request |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_refill_i | input | 1 | Read is a cache-miss refill |
| req_icache_i | input | 1 | Refill is for the instruction cache |
| req_addr_i | input | ADDR_W | Request address |
| req_wlen_i | input | CNT_W | Write beats minus one |
| cfg_dblk_refill_i | input | 1 | Enables block refill for data-cache misses |
| ack_i | input | 1 | Memory acknowledge |
| rdcap_i | input | 1 | Read-buffer capture enable |
| rdata_i | input | DATA_W | Read data from the bus |
| rd_o | output | 1 | Read transaction active |
| wr_o | output | 1 | Write transaction active |
| burst_near_o | output | 1 | Block request on reads, same-page back-to-back write on writes |
| addr_o | output | ADDR_W | Latched transaction address |
| done_o | output | 1 | Last cycle of the transaction |
| rbuf_we_o | output | 1 | Read-buffer write strobe |
| rbuf_idx_o | output | CNT_W | Read-buffer word index |
| rbuf_data_o | output | DATA_W | Read-buffer write data |

## Verification
The bench builds the block with ADDR_W=12, PAGE_W=8, DATA_W=16 and BLK_WORDS=4. This leaves only four page bits, so random addresses often match the previous write's page. Those matches come on top of the addresses the bench deliberately reuses, and the page-match and chain-break paths of R7 and R8 therefore get frequent exercise. BLK_WORDS=4 makes the 2-bit word counter wrap at the end of a block, and it allows write lengths up to four beats. The bench also gives delayed acknowledges, acknowledges that coincide with a capture, and captures after the last word.

// File: rtl/bns_pkg.sv
package bns_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } bns_state_e;
endpackage

// File: rtl/bns_beat_ctr.sv
module bns_beat_ctr #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] last_i,
  output logic [CNT_W-1:0] idx_o,
  output logic             at_last_o,
  output logic             full_o
);
  logic [CNT_W-1:0] idx_q;
  logic             full_q;

  assign at_last_o = (idx_q == last_i);
  assign idx_o     = idx_q;
  assign full_o    = full_q;

  // Counter wraps; full_q remembers that the last beat was counted.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      full_q <= 1'b0;
    end else if (clr_i) begin
      idx_q  <= '0;
      full_q <= 1'b0;
    end else if (inc_i) begin
      idx_q  <= idx_q + 1'b1;
      full_q <= full_q | at_last_o;
    end
  end
endmodule

// File: rtl/bns_page_track.sv
module bns_page_track #(
  parameter int unsigned PG_W = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_done_i,
  input  logic [PG_W-1:0] done_page_i,
  input  logic            break_i,
  input  logic [PG_W-1:0] cand_page_i,
  output logic            near_o
);
  logic            chain_q;
  logic [PG_W-1:0] page_q;

  assign near_o = chain_q && (cand_page_i == page_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= 1'b0;
      page_q  <= '0;
    end else if (wr_done_i) begin
      chain_q <= 1'b1;
      page_q  <= done_page_i;
    end else if (break_i) begin
      chain_q <= 1'b0;
    end
  end
endmodule

// File: rtl/burst_near_seq.sv
module burst_near_seq
  import bns_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned PAGE_W    = 8,
  parameter int unsigned BLK_WORDS = 4,
  localparam int unsigned CNT_W    = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_refill_i,
  input  logic              req_icache_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [CNT_W-1:0]  req_wlen_i,
  input  logic              cfg_dblk_refill_i,
  input  logic              ack_i,
  input  logic              rdcap_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              rd_o,
  output logic              wr_o,
  output logic              burst_near_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o,
  output logic              rbuf_we_o,
  output logic [CNT_W-1:0]  rbuf_idx_o,
  output logic [DATA_W-1:0] rbuf_data_o
);
  localparam int unsigned PG_W = ADDR_W - PAGE_W;
  localparam logic [CNT_W-1:0] BLK_LAST = CNT_W'(BLK_WORDS - 1);

  bns_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  last_q;
  logic              flag_q;

  logic accept, blk_req, near, wr_accept;
  logic ctr_clr, ctr_inc, at_last, full;
  logic rd_done, wr_done;

  assign accept    = (state_q == ST_IDLE) && req_valid_i;
  assign wr_accept = accept && req_write_i;
  assign blk_req   = req_refill_i && (req_icache_i || cfg_dblk_refill_i);

  assign ctr_clr = (state_q == ST_IDLE);
  assign ctr_inc = ((state_q == ST_RD) && rdcap_i && !full) ||
                   ((state_q == ST_WR) && ack_i);

  bns_beat_ctr #(.CNT_W(CNT_W)) u_beat_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (ctr_clr),
    .inc_i    (ctr_inc),
    .last_i   (last_q),
    .idx_o    (rbuf_idx_o),
    .at_last_o(at_last),
    .full_o   (full)
  );

  assign rd_done = (state_q == ST_RD) && ack_i && (full || (rdcap_i && at_last));
  assign wr_done = (state_q == ST_WR) && ack_i && at_last;

  bns_page_track #(.PG_W(PG_W)) u_page_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_done_i  (wr_done),
    .done_page_i(addr_q[ADDR_W-1:PAGE_W]),
    .break_i    ((state_q == ST_IDLE) && !wr_accept),
    .cand_page_i(req_addr_i[ADDR_W-1:PAGE_W]),
    .near_o     (near)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      last_q  <= '0;
      flag_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= req_write_i ? ST_WR : ST_RD;
          addr_q  <= req_addr_i;
          flag_q  <= req_write_i ? near : blk_req;
          last_q  <= req_write_i ? req_wlen_i : (blk_req ? BLK_LAST : '0);
        end
        ST_RD: if (rd_done) begin
          state_q <= ST_IDLE;
          flag_q  <= 1'b0;
        end
        ST_WR: if (wr_done) begin
          state_q <= ST_IDLE;
          flag_q  <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_o         = (state_q == ST_RD);
  assign wr_o         = (state_q == ST_WR);
  assign burst_near_o = flag_q && (rd_o || wr_o);
  assign addr_o       = addr_q;
  assign done_o       = rd_done || wr_done;
  assign rbuf_we_o    = rd_o && rdcap_i && !full;
  assign rbuf_data_o  = rdata_i;
endmodule

// File: rtl/bns_chk.sv
module bns_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_refill_i,
  input logic              req_icache_i,
  input logic              cfg_dblk_refill_i,
  input logic              ack_i,
  input logic              rdcap_i,
  input logic              rd_o,
  input logic              wr_o,
  input logic              burst_near_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              done_o,
  input logic              rbuf_we_o
);
  p_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o || wr_o) |-> (!burst_near_o && !done_o && !rbuf_we_o));

  p_one_dir_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_o || wr_o) && $past(rd_o || wr_o)) |->
      ($stable(burst_near_o) && $stable(addr_o) && $stable(rd_o)));

  p_burst_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_o) |->
      (burst_near_o == $past(req_refill_i && (req_icache_i || cfg_dblk_refill_i))));

  p_cap_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rbuf_we_o |-> (rd_o && rdcap_i));

  p_done_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ack_i);

  p_idle_after_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!rd_o && !wr_o));
endmodule

bind burst_near_seq bns_chk #(.ADDR_W(ADDR_W)) u_bns_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .req_refill_i     (req_refill_i),
  .req_icache_i     (req_icache_i),
  .cfg_dblk_refill_i(cfg_dblk_refill_i),
  .ack_i            (ack_i),
  .rdcap_i          (rdcap_i),
  .rd_o             (rd_o),
  .wr_o             (wr_o),
  .burst_near_o     (burst_near_o),
  .addr_o           (addr_o),
  .done_o           (done_o),
  .rbuf_we_o        (rbuf_we_o)
);

// File: tb/burst_near_seq_bench.sv
module burst_near_seq_bench;
  localparam int unsigned AW  = 12;
  localparam int unsigned DW  = 16;
  localparam int unsigned PW  = 8;
  localparam int unsigned BLK = 4;
  localparam int unsigned CW  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, req_refill = 1'b0, req_icache = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_wlen = '0;
  logic          cfg_dblk = 1'b0, ack = 1'b0, rdcap = 1'b0;
  logic [DW-1:0] rdata = '0;
  logic          rd, wr, bn, done, we;
  logic [AW-1:0] addr;
  logic [CW-1:0] idx;
  logic [DW-1:0] rbd;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;
  bit  m_chain = 1'b0;
  logic [AW-1:0] m_last = '0;

  always #10 clk = ~clk;

  burst_near_seq #(.ADDR_W(AW), .DATA_W(DW), .PAGE_W(PW), .BLK_WORDS(BLK)) u_burst_near_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_refill_i(req_refill), .req_icache_i(req_icache), .req_addr_i(req_addr),
    .req_wlen_i(req_wlen), .cfg_dblk_refill_i(cfg_dblk), .ack_i(ack), .rdcap_i(rdcap),
    .rdata_i(rdata), .rd_o(rd), .wr_o(wr), .burst_near_o(bn), .addr_o(addr),
    .done_o(done), .rbuf_we_o(we), .rbuf_idx_o(idx), .rbuf_data_o(rbd)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_blk(input bit refill, input bit ic, input bit dblk);
    return refill && (ic || dblk);
  endfunction

  function automatic bit exp_near(input logic [AW-1:0] a);
    return m_chain && (a[AW-1:PW] == m_last[AW-1:PW]);
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Entered at a negedge in the first idle cycle after the previous transaction.
  task automatic run_txn(input bit w, input logic [AW-1:0] a, input bit refill, input bit ic,
                         input bit dblk, input logic [CW-1:0] wlen, input int gap, input bit poke);
    bit en;
    int nw;
    repeat (gap) begin
      req_valid = 1'b0;
      #1 chk("R1 idle rd_o", rd, 0);
      step();
    end
    if (gap > 0) m_chain = 1'b0;
    en = w ? exp_near(a) : exp_blk(refill, ic, dblk);
    if (!w) m_chain = 1'b0;
    req_valid = 1'b1; req_write = w; req_addr = a; req_refill = refill;
    req_icache = ic; cfg_dblk = dblk; req_wlen = wlen;
    step();
    req_valid  = poke;
    req_write  = 1'($urandom);
    req_addr   = AW'($urandom);
    req_refill = 1'($urandom);
    req_icache = 1'($urandom);
    chk("R2 rd_o", rd, !w);
    chk("R2 wr_o", wr, w);
    chk("R2 addr_o", addr, a);
    chk(w ? "R7 burst_near_o write" : "R3 burst_near_o read", bn, en);
    if (!w) begin
      nw = en ? BLK : 1;
      for (int k = 0; k < nw; k++) begin
        int dly = $urandom % 3;
        repeat (dly) begin
          rdcap = 1'b0; ack = 1'($urandom);
          #1 chk("R5 early ack no done", done, 0);
          step();
        end
        rdcap = 1'b1; rdata = DW'($urandom);
        ack = 1'($urandom);
        #1;
        chk("R4 rbuf_we_o", we, 1);
        chk("R4 rbuf_idx_o", idx, k);
        chk("R4 rbuf_data_o", rbd, rdata);
        chk("R5 done_o on capture", done, (k == nw - 1) && ack);
        if (k == nw - 1 && !ack) begin
          step();
          rdcap = 1'b1; ack = 1'b0;
          #1 chk("R4 extra capture ignored", we, 0);
          chk("R5 no done without ack", done, 0);
          step();
          rdcap = 1'b0; ack = 1'b1;
          #1 chk("R5 done_o on late ack", done, 1);
        end
        step();
      end
    end else begin
      for (int b = 0; b <= int'(wlen); b++) begin
        int dly = $urandom % 3;
        repeat (dly) begin
          ack = 1'b0; rdcap = 1'($urandom);
          #1 chk("R4 capture during write ignored", we, 0);
          chk("R6 no done without ack", done, 0);
          step();
        end
        ack = 1'b1; rdcap = 1'b0;
        #1 chk("R6 done_o on beat ack", done, b == int'(wlen));
        step();
      end
      m_chain = 1'b1;
      m_last  = a;
    end
    ack = 1'b0; rdcap = 1'b0; req_valid = 1'b0;
    chk("R9 idle after done rd_o", rd, 0);
    chk("R9 idle after done wr_o", wr, 0);
    chk("R1 idle burst_near_o", bn, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd91));
    repeat (2) @(negedge clk);
    chk("R1 reset rd_o", rd, 0);
    chk("R1 reset wr_o", wr, 0);
    chk("R1 reset burst_near_o", bn, 0);
    chk("R1 reset done_o", done, 0);
    rdcap = 1'b1;
    #1 chk("R1 reset rbuf_we_o", we, 0);
    rdcap = 1'b0;
    rst_n = 1'b1;
    step();

    // R7: same page back-to-back, then a different page, then the same page again.
    run_txn(1, 12'h1A0, 0, 0, 0, 0, 0, 0);
    run_txn(1, 12'h1F4, 0, 0, 0, 0, 0, 0);
    run_txn(1, 12'h2F4, 0, 0, 0, 1, 0, 1);
    run_txn(1, 12'h207, 0, 0, 0, 3, 0, 0);
    // R8: an idle gap breaks the chain.
    run_txn(1, 12'h2AA, 0, 0, 0, 0, 1, 0);
    // R8: an intervening read breaks the chain.
    run_txn(0, 12'h2AB, 0, 0, 0, 0, 0, 0);
    run_txn(1, 12'h2AC, 0, 0, 0, 0, 0, 0);
    // R3: the refill variants.
    run_txn(0, 12'h300, 1, 1, 0, 0, 0, 1);
    run_txn(0, 12'h310, 1, 0, 0, 0, 0, 0);
    run_txn(0, 12'h320, 1, 0, 1, 0, 0, 0);
    run_txn(0, 12'h330, 0, 1, 1, 0, 0, 1);
    // R6: the longest write.
    run_txn(1, 12'h400, 0, 0, 0, 2'd3, 0, 1);

    for (int i = 0; i < 300; i++) begin
      bit w = 1'($urandom);
      logic [AW-1:0] a = AW'($urandom);
      if ($urandom % 2) a[AW-1:PW] = m_last[AW-1:PW];
      run_txn(w, a, 1'($urandom), 1'($urandom), 1'($urandom), CW'($urandom),
              ($urandom % 4 == 0) ? 1 + $urandom % 2 : 0, 1'($urandom));
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule